// File: doc/BRIEF.md
# Standby Sparing Reconfiguration Controller

This controller runs a computer made of stacked levels of interchangeable modules, with one level per module type. Each level holds `NUM_MOD` identical modules. In cruise operation exactly one module per level is powered. Crosspoint switches join one chosen module on each level to one chosen module on the level above, so together they form a single operating string. The other modules stay powered down as cold spares. The controller keeps a sticky failed record per module. It watches the failure flags of the crosspoints, which are honoured at every cycle. When the string breaks, it rebuilds the string within a bounded number of cycles.

A broken string is repaired in one of two ways. If only one active module has failed, the controller swaps in the lowest-index spare that has working links to both neighbouring chosen modules. In every other case it picks a whole new string, level by level, preferring low indices and accepting only modules that can still reach the top level through working links. During boost, every unfailed module is powered and the straight-across crosspoints form parallel strings for voting. Leaving boost triggers a fresh string selection. A system-failure flag reports when no complete string exists.

Top module: `modred_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pwr_en_o`, `xsel_o` and `busy_o` are all zero. In cruise after release, `busy_o` is high after the first edge, and the second edge commits a string.
- R2: A module flagged on `mod_fail_i` at any edge stays failed until reset. No committed string and no boost pattern ever powers a module that was failed before the edge that produced it.
- R3: Outside boost, a committed string powers at most one module per level. `pwr_en_o` bit `l*NUM_MOD+m` is module m of level l. Exactly one crosspoint per switch is closed, joining the chosen modules. `xsel_o` and `xp_fail_i` bit `s*NUM_MOD*NUM_MOD+a*NUM_MOD+b` joins module a of level s to module b of level s+1.
- R4: A full selection takes, on level 0, the lowest-index module from which an unfailed path with working links reaches the top level. On each higher level it takes the lowest-index such module linked to the choice below.
- R5: When exactly one active module has failed and every active link works, that module is replaced by the lowest-index unfailed module with working links to both neighbouring chosen modules. Other levels keep their choice.
- R6: A failed active link, more than one failed active module, no usable spare, or a previously dead system leads to a full selection.
- R7: A fault seen at edge k raises `busy_o` at the next edge at which the broken string is visible, and the following edge commits. `busy_o` lasts exactly one cycle. Outside boost, `pwr_en_o` and `xsel_o` change only at a commit.
- R8: With `boost_i` high, each edge powers every unfailed module. It also closes each crosspoint joining module i of adjacent levels, provided both modules are unfailed and the link works. `busy_o` stays low. After `boost_i` falls, a full selection follows.
- R9: `sys_fail_o` is high exactly when no complete string exists. A commit without a string switches all power and crosspoints off. No further reconfiguration starts until a string becomes available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boost_i | input | 1 | Boost phase, all strings in parallel |
| mod_fail_i | input | NUM_LVL*NUM_MOD | Module fault flags, sampled every edge |
| xp_fail_i | input | (NUM_LVL-1)*NUM_MOD*NUM_MOD | Crosspoint fault flags |
| pwr_en_o | output | NUM_LVL*NUM_MOD | Module power enables |
| xsel_o | output | (NUM_LVL-1)*NUM_MOD*NUM_MOD | Crosspoint closes |
| busy_o | output | 1 | Reconfiguration in progress |
| sys_fail_o | output | 1 | No complete string exists |

## Verification
Directed sequences cover these cases:
- a single failed active module, where the repair must leave the other levels unchanged;
- a broken active link, where a full selection must detour around the link;
- the loss of a whole level, which separates a dead system from a repair;
- boost entry and exit with an early failure, which shows the parallel pattern and the fresh selection that follows.

Seeded random runs toggle boost and sprinkle module faults and flapping crosspoint faults. These runs reach multiple faults, faults arriving during a pending commit, and recovery after crosspoint flags clear. A cycle-level reference model compares every output on every cycle of these runs.

// File: rtl/modred_pkg.sv
package modred_pkg;
  localparam int unsigned NO_IDX = 32;

  function automatic int unsigned lowest_set(input logic [31:0] v);
    lowest_set = NO_IDX;
    for (int i = 31; i >= 0; i--) if (v[i]) lowest_set = i;
  endfunction
endpackage

// File: rtl/modred_reach.sv
module modred_reach #(
  parameter int unsigned NL = 4,
  parameter int unsigned NM = 3
) (
  input  logic [NL-1:0][NM-1:0]          fail_i,
  input  logic [NL-2:0][NM-1:0][NM-1:0]  xp_i,
  output logic [NL-1:0][NM-1:0]          ok_o
);
  // ok: unfailed and a working path to the top level exists
  always_comb begin
    ok_o[NL-1] = ~fail_i[NL-1];
    for (int l = NL - 2; l >= 0; l--)
      for (int a = 0; a < NM; a++)
        ok_o[l][a] = ~fail_i[l][a] & |(ok_o[l+1] & ~xp_i[l][a]);
  end
endmodule

// File: rtl/modred_pick.sv
module modred_pick
  import modred_pkg::*;
#(
  parameter int unsigned NL = 4,
  parameter int unsigned NM = 3,
  localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NL-1:0][NM-1:0]          fail_i,
  input  logic [NL-2:0][NM-1:0][NM-1:0]  xp_i,
  input  logic [NL-1:0][NM-1:0]          ok_i,
  input  logic [NL-1:0][IW-1:0]          sel_i,
  input  logic                           full_i,
  output logic [NL-1:0][IW-1:0]          nsel_o,
  output logic                           bad_o
);
  logic [NL-1:0][NM-1:0] cand;

  for (genvar l = 0; l < NL; l++) begin : g_cand
    logic [NM-1:0] in_ok, out_ok;
    if (l == 0) begin : g_bot
      assign in_ok = '1;
    end else begin : g_in
      assign in_ok = ~xp_i[l-1][sel_i[l-1]];
    end
    if (l == NL - 1) begin : g_top
      assign out_ok = '1;
    end else begin : g_out
      for (genvar c = 0; c < NM; c++) begin : g_c
        assign out_ok[c] = ~xp_i[l][c][sel_i[l+1]];
      end
    end
    assign cand[l] = ~fail_i[l] & in_ok & out_ok;
  end

  logic [NL-1:0]         bm;
  logic                  bl, rep_ok;
  logic [NL-1:0][IW-1:0] fs, rs;
  int unsigned           idx;

  always_comb begin
    bl = 1'b0;
    for (int l = 0; l < NL; l++) bm[l] = fail_i[l][sel_i[l]];
    for (int s = 0; s < NL - 1; s++) bl = bl | xp_i[s][sel_i[s]][sel_i[s+1]];
    // full selection, lowest index first
    fs[0] = IW'(lowest_set(32'(ok_i[0])));
    for (int l = 1; l < NL; l++)
      fs[l] = IW'(lowest_set(32'(ok_i[l] & ~xp_i[l-1][fs[l-1]])));
    // single-module repair
    rs = sel_i;
    rep_ok = 1'b0;
    idx = NO_IDX;
    if (!full_i && $countones(bm) == 1 && !bl) begin
      for (int l = 0; l < NL; l++) begin
        if (bm[l]) begin
          idx = lowest_set(32'(cand[l]));
          if (idx != NO_IDX) begin
            rs[l] = IW'(idx);
            rep_ok = 1'b1;
          end
        end
      end
    end
    nsel_o = rep_ok ? rs : fs;
    bad_o  = |bm | bl;
  end
endmodule

// File: rtl/modred_ctrl.sv
module modred_ctrl #(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned NUM_MOD = 3,
  localparam int unsigned IW = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
  localparam int unsigned NX = (NUM_LVL - 1) * NUM_MOD * NUM_MOD
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       boost_i,
  input  logic [NUM_LVL*NUM_MOD-1:0] mod_fail_i,
  input  logic [NX-1:0]              xp_fail_i,
  output logic [NUM_LVL*NUM_MOD-1:0] pwr_en_o,
  output logic [NX-1:0]              xsel_o,
  output logic                       busy_o,
  output logic                       sys_fail_o
);
  localparam int unsigned NL = NUM_LVL;
  localparam int unsigned NM = NUM_MOD;

  logic [NL-1:0][NM-1:0]         mf_in, fail_q, ok, pwr_q, sp, bp;
  logic [NL-2:0][NM-1:0][NM-1:0] xp, xsel_q, sx, bx;
  logic [NL-1:0][IW-1:0]         sel_q, nsel;
  logic busy_q, full_q, dead_q, bad, any_ok, trigger;

  assign mf_in = mod_fail_i;
  assign xp    = xp_fail_i;

  modred_reach #(.NL(NL), .NM(NM)) u_reach (
    .fail_i(fail_q), .xp_i(xp), .ok_o(ok)
  );

  modred_pick #(.NL(NL), .NM(NM)) u_pick (
    .fail_i(fail_q), .xp_i(xp), .ok_i(ok), .sel_i(sel_q),
    .full_i(full_q | dead_q), .nsel_o(nsel), .bad_o(bad)
  );

  assign any_ok  = |ok[0];
  assign trigger = full_q | (dead_q ? any_ok : bad);

  always_comb begin
    sp = '0;
    sx = '0;
    bx = '0;
    bp = ~fail_q;
    for (int l = 0; l < NL; l++) sp[l][nsel[l]] = 1'b1;
    for (int s = 0; s < NL - 1; s++) begin
      sx[s][nsel[s]][nsel[s+1]] = 1'b1;
      for (int i = 0; i < NM; i++)
        bx[s][i][i] = ~fail_q[s][i] & ~fail_q[s+1][i] & ~xp[s][i][i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= '0;
      sel_q  <= '0;
      pwr_q  <= '0;
      xsel_q <= '0;
      busy_q <= 1'b0;
      full_q <= 1'b1;
      dead_q <= 1'b0;
    end else begin
      fail_q <= fail_q | mf_in;
      if (boost_i) begin
        pwr_q  <= bp;
        xsel_q <= bx;
        busy_q <= 1'b0;
        full_q <= 1'b1;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        full_q <= 1'b0;
        if (any_ok) begin
          sel_q  <= nsel;
          pwr_q  <= sp;
          xsel_q <= sx;
          dead_q <= 1'b0;
        end else begin
          pwr_q  <= '0;
          xsel_q <= '0;
          dead_q <= 1'b1;
        end
      end else if (trigger) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign pwr_en_o   = pwr_q;
  assign xsel_o     = xsel_q;
  assign busy_o     = busy_q;
  assign sys_fail_o = ~any_ok;

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q & $past(fail_q)) == $past(fail_q)); // R2
  AST_NO_FAILED_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_q) && !$past(boost_i)) |-> ((pwr_q & $past(fail_q)) == '0)); // R2
  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q); // R7
  AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_q) && !$past(boost_i)) |-> ($stable(xsel_q) && $stable(pwr_q))); // R7
  AST_DEAD_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_q && !any_ok && !boost_i) |-> (pwr_q == '0 && xsel_q == '0)); // R9
  for (genvar l = 0; l < NL; l++) begin : g_ast
    AST_ONE_PER_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !full_q |-> $onehot0(pwr_q[l])); // R3
  end
endmodule

// File: tb/tb_modred_ctrl.sv
module tb_modred_ctrl;
  localparam int NL = 4;
  localparam int NM = 3;
  localparam int NB = NL * NM;
  localparam int NX = (NL - 1) * NM * NM;

  logic clk = 1'b0, rst_n = 1'b0, boost = 1'b0;
  logic [NB-1:0] mf = '0;
  logic [NX-1:0] xf = '0;
  logic [NB-1:0] pwr_en;
  logic [NX-1:0] xsel;
  logic busy, sys_fail;

  int checks = 0, errors = 0;
  bit done = 0;

  modred_ctrl #(.NUM_LVL(NL), .NUM_MOD(NM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .boost_i(boost), .mod_fail_i(mf), .xp_fail_i(xf),
    .pwr_en_o(pwr_en), .xsel_o(xsel), .busy_o(busy), .sys_fail_o(sys_fail)
  );

  always #4 clk = ~clk;

  // reference model
  logic [NB-1:0] m_fail = '0, m_pwr = '0;
  logic [NX-1:0] m_xs = '0;
  int  m_sel [NL];
  bit  m_busy = 0, m_full = 1, m_dead = 0;
  bit  okm [NL][NM];

  function automatic int xi(int s, int a, int b); return s*NM*NM + a*NM + b; endfunction
  function automatic int mi(int l, int m); return l*NM + m; endfunction

  function automatic bit fill_ok();
    bit any = 0;
    for (int l = NL - 1; l >= 0; l--)
      for (int m = 0; m < NM; m++) begin
        okm[l][m] = !m_fail[mi(l, m)];
        if (l < NL - 1) begin
          bit r = 0;
          for (int b = 0; b < NM; b++) if (okm[l+1][b] && !xf[xi(l, m, b)]) r = 1;
          okm[l][m] = okm[l][m] && r;
        end
      end
    for (int m = 0; m < NM; m++) if (okm[0][m]) any = 1;
    return any;
  endfunction

  task automatic model_step();
    bit any, bl, rep;
    int nbad, ns [NL];
    any = fill_ok();
    nbad = 0; bl = 0;
    for (int l = 0; l < NL; l++) if (m_fail[mi(l, m_sel[l])]) nbad++;
    for (int s = 0; s < NL - 1; s++) if (xf[xi(s, m_sel[s], m_sel[s+1])]) bl = 1;
    if (boost) begin
      m_pwr = ~m_fail; m_xs = '0;
      for (int s = 0; s < NL - 1; s++)
        for (int i = 0; i < NM; i++)
          if (!m_fail[mi(s, i)] && !m_fail[mi(s+1, i)] && !xf[xi(s, i, i)]) m_xs[xi(s, i, i)] = 1;
      m_busy = 0; m_full = 1;
    end else if (m_busy) begin
      rep = 0;
      for (int l = 0; l < NL; l++) ns[l] = m_sel[l];
      if (!m_full && !m_dead && nbad == 1 && !bl)
        for (int l = 0; l < NL; l++)
          if (m_fail[mi(l, m_sel[l])])
            for (int c = NM - 1; c >= 0; c--)
              if (!m_fail[mi(l, c)] && (l == 0 || !xf[xi(l-1, m_sel[l-1], c)]) &&
                  (l == NL - 1 || !xf[xi(l, c, m_sel[l+1])])) begin
                ns[l] = c; rep = 1;
              end
      if (!rep) begin
        for (int m = NM - 1; m >= 0; m--) if (okm[0][m]) ns[0] = m;
        for (int l = 1; l < NL; l++)
          for (int m = NM - 1; m >= 0; m--)
            if (okm[l][m] && !xf[xi(l-1, ns[l-1], m)]) ns[l] = m;
      end
      m_busy = 0; m_full = 0;
      if (any) begin
        m_pwr = '0; m_xs = '0; m_dead = 0;
        for (int l = 0; l < NL; l++) begin m_sel[l] = ns[l]; m_pwr[mi(l, ns[l])] = 1; end
        for (int s = 0; s < NL - 1; s++) m_xs[xi(s, ns[s], ns[s+1])] = 1;
      end else begin
        m_pwr = '0; m_xs = '0; m_dead = 1;
      end
    end else if (m_full || (m_dead ? any : (nbad > 0 || bl))) begin
      m_busy = 1;
    end
    m_fail = m_fail | mf;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fail = '0; m_pwr = '0; m_xs = '0; m_busy = 0; m_full = 1; m_dead = 0;
      for (int l = 0; l < NL; l++) m_sel[l] = 0;
    end else model_step();
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(boost ? "R8 R2 model pwr" : "R3 R4 R5 R6 model pwr", 64'(pwr_en), 64'(m_pwr));
      chk(boost ? "R8 model xsel" : "R3 R6 model xsel", 64'(xsel), 64'(m_xs));
      chk("R7 model busy", 64'(busy), 64'(m_busy));
      chk("R9 model sys_fail", 64'(sys_fail), 64'(!fill_ok()));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit bst);
    rst_n = 0; mf = '0; xf = '0; boost = bst;
    step(2);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    // R1 reset state
    step(3);
    chk("R1 reset pwr", 64'(pwr_en), 0);
    chk("R1 reset xsel", 64'(xsel), 0);
    chk("R1 reset busy", 64'(busy), 0);
    chk("R9 reset sys_fail", 64'(sys_fail), 0);
    rst_n = 1;
    step();
    chk("R1 R7 first busy", 64'(busy), 1);
    step();
    chk("R4 first string pwr", 64'(pwr_en), 64'h249);
    chk("R3 first string xsel", 64'(xsel), 64'h40201);
    // R5 single module repair
    mf[mi(1, 0)] = 1;
    step(); mf = '0;
    chk("R7 no busy before seen", 64'(busy), 0);
    step();
    chk("R7 busy one edge later", 64'(busy), 1);
    chk("R7 pwr held while busy", 64'(pwr_en), 64'h249);
    step();
    chk("R5 repaired pwr", 64'(pwr_en), 64'h251);
    chk("R7 busy cleared", 64'(busy), 0);
    // R6 active link fault
    xf[xi(2, 0, 0)] = 1;
    step();
    chk("R6 busy on link fault", 64'(busy), 1);
    step();
    chk("R6 full reselect pwr", 64'(pwr_en), 64'h451);
    // R9 whole level lost
    mf[mi(2, 0)] = 1; mf[mi(2, 1)] = 1; mf[mi(2, 2)] = 1;
    step(); mf = '0;
    chk("R9 sys_fail raised", 64'(sys_fail), 1);
    step(2);
    chk("R9 dead pwr off", 64'(pwr_en), 0);
    chk("R9 dead xsel off", 64'(xsel), 0);
    step(3);
    chk("R9 no retrigger", 64'(busy), 0);
    // R8 boost
    do_reset(1'b1);
    step();
    chk("R8 boost pwr", 64'(pwr_en), 64'hFFF);
    chk("R8 boost xsel", 64'(xsel), 64'h4462311);
    chk("R8 boost busy", 64'(busy), 0);
    mf[mi(0, 0)] = 1;
    step(); mf = '0;
    step();
    chk("R2 R8 failed dropped in boost", 64'(pwr_en), 64'hFFE);
    boost = 0;
    step();
    chk("R8 exit busy", 64'(busy), 1);
    step();
    chk("R8 R4 exit selection", 64'(pwr_en), 64'h24A);
    // random segments
    for (int seg = 0; seg < 4; seg++) begin
      do_reset(1'b0);
      for (int n = 0; n < 3000; n++) begin
        step();
        mf = '0;
        if ($urandom % 50 == 0) mf[$urandom % NB] = 1;
        if ($urandom % 80 == 0) xf[$urandom % NX] = ~xf[$urandom % NX];
        if ($urandom % 400 == 0) boost = ~boost;
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule